// File: doc/BRIEF.md
# Banked Working Register File

This block is the working-register front end of a small 8-bit core's internal RAM. The RAM holds 128 bytes, at addresses 00H to 7FH. Its lowest 32 bytes form four banks of eight working registers each. A held two-bit bank value chooses the active bank. A three-bit register index n then resolves to the byte address `{bank, n}`. Bank 0 covers 00H–07H, bank 1 covers 08H–0FH, bank 2 covers 10H–17H and bank 3 covers 18H–1FH.

The block has five access paths:
- A register read port.
- A register write port.
- A direct byte-address port into the same 32 bytes.
- A bank load input.
- An indirect access engine. This engine takes the byte held in register 0 or register 1 of the active bank and uses it as a RAM address for one read or one write.

A small state machine sequences each indirect access through three states:
- `IND_IDLE`: the engine waits. On a request it captures the command and the pointer's location, then moves to `IND_FETCH`.
- `IND_FETCH`: the engine reads the pointer byte, then always moves to `IND_ACCESS`.
- `IND_ACCESS`: the engine performs the read or write, or flags the pointer as invalid. It then always returns to `IND_IDLE`.

Top module: `wrf_banked_regs`

## Requirements
- R1: `rd_data` shows, one clock after `rd_idx` is presented, the byte at address `{cur_bank, rd_idx}`. A `wr_en` write stores `wr_data` at `{cur_bank, wr_idx}`. Addresses are zero-extended to 7 bits.
- R2: The bank encoding is 0 → 00H–07H, 1 → 08H–0FH, 2 → 10H–17H and 3 → 18H–1FH. When `bank_wr_en` is high at a clock edge, `cur_bank` takes `bank_wr_val` from that edge on. Otherwise `cur_bank` holds its value. Any access made in the same cycle as a bank load still uses the old bank.
- R3: After reset, `cur_bank` is 0. All RAM bytes are 00H. `rd_data`, `dir_rdata`, `ind_rdata`, `ind_done` and `ind_invalid` are 0, and the engine is idle (`ind_busy` is 0).
- R4: The direct port addresses bytes 00H–1FH through the 5-bit `dir_addr`. `dir_rdata` shows the addressed byte one clock later. A direct write is visible to a later register read in the matching bank, and a register write is visible to a later direct read.
- R5: An indirect request (`ind_req` high while `ind_busy` is low) is accepted at a clock edge. The pointer is taken from register `ind_sel` (0 = register 0, 1 = register 1) of the bank active at that edge. `ind_busy` is then high for exactly two cycles. `ind_done` pulses for one cycle after the third edge, counting from the acceptance edge.
- R6: An indirect access with a pointer below 80H does one of two things. A write (`ind_we` = 1) stores `ind_wdata` at the pointer address. A read loads `ind_rdata` with the byte at that address, and `ind_rdata` holds that value until the next valid indirect read completes.
- R7: An indirect access with a pointer of 80H or above raises `ind_invalid` together with `ind_done`. It writes no RAM byte and leaves `ind_rdata` unchanged.
- R8: If a read and a write hit the same byte in one cycle, the read returns the value from before the write.
- R9: If several writes hit the same byte in one cycle, the indirect write wins over the direct write, and the direct write wins over the register write.
- R10: An `ind_req` that arrives while `ind_busy` is high is ignored.
- R11: `ind_invalid` is low in the completion cycle of an indirect access with a valid pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_wr_en | input | 1 | Load a new bank value |
| bank_wr_val | input | 2 | Bank value to load |
| cur_bank | output | 2 | Active bank |
| rd_idx | input | 3 | Register index for the read port |
| rd_data | output | 8 | Registered read data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 3 | Register index for the write port |
| wr_data | input | 8 | Register write data |
| dir_addr | input | 5 | Direct byte address (00H–1FH) |
| dir_we | input | 1 | Direct write enable |
| dir_wdata | input | 8 | Direct write data |
| dir_rdata | output | 8 | Registered direct read data |
| ind_req | input | 1 | Start an indirect access |
| ind_sel | input | 1 | Pointer register: 0 = register 0, 1 = register 1 |
| ind_we | input | 1 | Indirect access is a write |
| ind_wdata | input | 8 | Indirect write data |
| ind_busy | output | 1 | Indirect engine is not idle |
| ind_done | output | 1 | One-cycle completion pulse |
| ind_invalid | output | 1 | Pointer was 80H or above; pulses with `ind_done` |
| ind_rdata | output | 8 | Last valid indirect read data |

## Verification
A wrong bank register shows up on `rd_data` one cycle after the next register read. The value appears to come from a different 8-byte group, which the direct port then exposes as a mismatch. A wrong address mapping or a lost write stays hidden until that byte is read back. For this reason the reference model compares `rd_data` and `dir_rdata` against its own copy of the RAM on every clock. A fault in the indirect engine shows up within three cycles of acceptance, as a mistimed `ind_busy` or `ind_done`. A fault in the pointer path or the range check shows up later: a wrong `ind_rdata`, or a byte corrupted by an invalid pointer and seen on a later read.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    // Sequencing of one indirect access
    typedef enum logic [1:0] {
        IND_IDLE   = 2'd0,
        IND_FETCH  = 2'd1,
        IND_ACCESS = 2'd2
    } ind_state_e;

    // RAM read port assignment
    localparam int RP_REG = 0;
    localparam int RP_DIR = 1;
    localparam int RP_IND = 2;
    localparam int RP_NUM = 3;

    // RAM write port assignment; a higher index wins on the same byte
    localparam int WP_REG = 0;
    localparam int WP_DIR = 1;
    localparam int WP_IND = 2;
    localparam int WP_NUM = 3;

endpackage

// File: rtl/wrf_bank_ctl.sv
module wrf_bank_ctl #(
    parameter int BANK_W = 2,
    parameter int IDX_W  = 3,
    parameter int AW     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_wr_en,
    input  logic [BANK_W-1:0] bank_wr_val,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              ptr_sel,
    output logic [BANK_W-1:0] bank_q,
    output logic [AW-1:0]     rd_addr,
    output logic [AW-1:0]     wr_addr,
    output logic [AW-1:0]     ptr_addr
);

    localparam int REG_AW = BANK_W + IDX_W;

    logic [IDX_W-1:0] ptr_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (bank_wr_en) begin
            bank_q <= bank_wr_val;
        end
    end

    assign ptr_idx = {{(IDX_W-1){1'b0}}, ptr_sel};

    // Register byte address: zero-extended {bank, index}
    assign rd_addr  = AW'({bank_q, rd_idx});
    assign wr_addr  = AW'({bank_q, wr_idx});
    assign ptr_addr = AW'({bank_q, ptr_idx});

    // Register space must fit into the RAM
    initial begin
        if (REG_AW > AW) $error("register space exceeds RAM address width");
    end

endmodule

// File: rtl/wrf_ram.sv
module wrf_ram #(
    parameter int DW  = 8,
    parameter int AW  = 7,
    parameter int NRD = 3,
    parameter int NWR = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] raddr [NRD],
    output logic [DW-1:0] rdata [NRD],
    input  logic          we    [NWR],
    input  logic [AW-1:0] waddr [NWR],
    input  logic [DW-1:0] wdata [NWR]
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    // Later ports in the loop override earlier ones on the same byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int w = 0; w < NWR; w++) begin
                if (we[w]) begin
                    mem_q[waddr[w]] <= wdata[w];
                end
            end
        end
    end

    generate
        for (genvar r = 0; r < NRD; r++) begin : g_rd
            assign rdata[r] = mem_q[raddr[r]];
        end
    endgenerate

endmodule

// File: rtl/wrf_ind_fsm.sv
module wrf_ind_fsm
    import wrf_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_we,
    input  logic [DW-1:0] req_wdata,
    input  logic [AW-1:0] src_addr,
    input  logic [DW-1:0] ram_rdata,
    output logic [AW-1:0] ram_raddr,
    output logic          ram_we,
    output logic [AW-1:0] ram_waddr,
    output logic [DW-1:0] ram_wdata,
    output logic          busy,
    output logic          done,
    output logic          invalid,
    output logic [DW-1:0] rdata
);

    ind_state_e    state_q, state_d;
    logic          we_q;
    logic [DW-1:0] wd_q;
    logic [AW-1:0] src_q;
    logic [DW-1:0] ptr_q;
    logic          ptr_ok;
    logic          done_q, invalid_q;
    logic [DW-1:0] rdata_q;

    assign ptr_ok = (ptr_q[DW-1:AW] == '0);

    // Transition logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IND_IDLE:   state_d = req ? IND_FETCH : IND_IDLE;
            IND_FETCH:  state_d = IND_ACCESS;
            IND_ACCESS: state_d = IND_IDLE;
            default:    state_d = IND_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IND_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Captured command and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q      <= 1'b0;
            wd_q      <= '0;
            src_q     <= '0;
            ptr_q     <= '0;
            done_q    <= 1'b0;
            invalid_q <= 1'b0;
            rdata_q   <= '0;
        end else begin
            done_q    <= 1'b0;
            invalid_q <= 1'b0;
            unique case (state_q)
                IND_IDLE: begin
                    if (req) begin
                        we_q  <= req_we;
                        wd_q  <= req_wdata;
                        src_q <= src_addr;
                    end
                end
                IND_FETCH: begin
                    ptr_q <= ram_rdata;
                end
                IND_ACCESS: begin
                    done_q    <= 1'b1;
                    invalid_q <= !ptr_ok;
                    if (ptr_ok && !we_q) begin
                        rdata_q <= ram_rdata;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign ram_raddr = (state_q == IND_FETCH) ? src_q : ptr_q[AW-1:0];
    assign ram_we    = (state_q == IND_ACCESS) && we_q && ptr_ok;
    assign ram_waddr = ptr_q[AW-1:0];
    assign ram_wdata = wd_q;
    assign busy      = (state_q != IND_IDLE);
    assign done      = done_q;
    assign invalid   = invalid_q;
    assign rdata     = rdata_q;

endmodule

// File: rtl/wrf_banked_regs.sv
module wrf_banked_regs
    import wrf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3,
    parameter int BANK_W = 2,
    parameter int RAM_AW = 7,
    localparam int DIR_AW = BANK_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_wr_en,
    input  logic [BANK_W-1:0] bank_wr_val,
    output logic [BANK_W-1:0] cur_bank,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DIR_AW-1:0] dir_addr,
    input  logic              dir_we,
    input  logic [DATA_W-1:0] dir_wdata,
    output logic [DATA_W-1:0] dir_rdata,
    input  logic              ind_req,
    input  logic              ind_sel,
    input  logic              ind_we,
    input  logic [DATA_W-1:0] ind_wdata,
    output logic              ind_busy,
    output logic              ind_done,
    output logic              ind_invalid,
    output logic [DATA_W-1:0] ind_rdata
);

    logic [RAM_AW-1:0] reg_rd_addr, reg_wr_addr, ptr_src_addr;
    logic [RAM_AW-1:0] rp_addr [RP_NUM];
    logic [DATA_W-1:0] rp_data [RP_NUM];
    logic              wp_en   [WP_NUM];
    logic [RAM_AW-1:0] wp_addr [WP_NUM];
    logic [DATA_W-1:0] wp_data [WP_NUM];

    logic [RAM_AW-1:0] ind_raddr, ind_waddr;
    logic              ind_wen;
    logic [DATA_W-1:0] ind_wval;
    logic [DATA_W-1:0] rd_data_q, dir_rdata_q;

    wrf_bank_ctl #(
        .BANK_W (BANK_W),
        .IDX_W  (IDX_W),
        .AW     (RAM_AW)
    ) bank_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bank_wr_en  (bank_wr_en),
        .bank_wr_val (bank_wr_val),
        .rd_idx      (rd_idx),
        .wr_idx      (wr_idx),
        .ptr_sel     (ind_sel),
        .bank_q      (cur_bank),
        .rd_addr     (reg_rd_addr),
        .wr_addr     (reg_wr_addr),
        .ptr_addr    (ptr_src_addr)
    );

    wrf_ind_fsm #(
        .DW (DATA_W),
        .AW (RAM_AW)
    ) ind_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (ind_req),
        .req_we    (ind_we),
        .req_wdata (ind_wdata),
        .src_addr  (ptr_src_addr),
        .ram_rdata (rp_data[RP_IND]),
        .ram_raddr (ind_raddr),
        .ram_we    (ind_wen),
        .ram_waddr (ind_waddr),
        .ram_wdata (ind_wval),
        .busy      (ind_busy),
        .done      (ind_done),
        .invalid   (ind_invalid),
        .rdata     (ind_rdata)
    );

    // Read port wiring
    assign rp_addr[RP_REG] = reg_rd_addr;
    assign rp_addr[RP_DIR] = RAM_AW'(dir_addr);
    assign rp_addr[RP_IND] = ind_raddr;

    // Write port wiring, lowest priority first
    assign wp_en[WP_REG]   = wr_en;
    assign wp_addr[WP_REG] = reg_wr_addr;
    assign wp_data[WP_REG] = wr_data;
    assign wp_en[WP_DIR]   = dir_we;
    assign wp_addr[WP_DIR] = RAM_AW'(dir_addr);
    assign wp_data[WP_DIR] = dir_wdata;
    assign wp_en[WP_IND]   = ind_wen;
    assign wp_addr[WP_IND] = ind_waddr;
    assign wp_data[WP_IND] = ind_wval;

    wrf_ram #(
        .DW  (DATA_W),
        .AW  (RAM_AW),
        .NRD (RP_NUM),
        .NWR (WP_NUM)
    ) ram_i (
        .clk   (clk),
        .rst_n (rst_n),
        .raddr (rp_addr),
        .rdata (rp_data),
        .we    (wp_en),
        .waddr (wp_addr),
        .wdata (wp_data)
    );

    // Registered read ports sample the byte before this edge's writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_q   <= '0;
            dir_rdata_q <= '0;
        end else begin
            rd_data_q   <= rp_data[RP_REG];
            dir_rdata_q <= rp_data[RP_DIR];
        end
    end

    assign rd_data   = rd_data_q;
    assign dir_rdata = dir_rdata_q;

endmodule

// File: rtl/wrf_banked_regs_chk.sv
module wrf_banked_regs_chk #(
    parameter int BANK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bank_wr_en,
    input logic [BANK_W-1:0] bank_wr_val,
    input logic [BANK_W-1:0] cur_bank,
    input logic              ind_req,
    input logic              ind_busy,
    input logic              ind_done,
    input logic              ind_invalid
);

    // R2
    bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr_en |=> cur_bank == $past(bank_wr_val));

    // R2
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_wr_en |=> $stable(cur_bank));

    // R5
    ind_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_req && !ind_busy) |=> ind_busy);

    // R5
    ind_busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ind_busy) |=> ind_busy);

    // R5
    ind_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ind_done |=> !ind_done);

    // R5
    ind_done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ind_done |-> (!ind_busy && $past(ind_busy)));

    // R7
    ind_invalid_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ind_invalid |-> ind_done);

endmodule

bind wrf_banked_regs wrf_banked_regs_chk #(
    .BANK_W (BANK_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bank_wr_en  (bank_wr_en),
    .bank_wr_val (bank_wr_val),
    .cur_bank    (cur_bank),
    .ind_req     (ind_req),
    .ind_busy    (ind_busy),
    .ind_done    (ind_done),
    .ind_invalid (ind_invalid)
);

// File: tb/wrf_banked_regs_tb_top.sv
module wrf_banked_regs_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bank_wr_en;
    logic [1:0] bank_wr_val, cur_bank;
    logic [2:0] rd_idx, wr_idx;
    logic [7:0] rd_data, wr_data, dir_wdata, dir_rdata, ind_wdata, ind_rdata;
    logic       wr_en, dir_we, ind_req, ind_sel, ind_we;
    logic [4:0] dir_addr;
    logic       ind_busy, ind_done, ind_invalid;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 0;

    always #5 clk = ~clk;

    wrf_banked_regs dut_i (
        .clk(clk), .rst_n(rst_n),
        .bank_wr_en(bank_wr_en), .bank_wr_val(bank_wr_val), .cur_bank(cur_bank),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .dir_addr(dir_addr), .dir_we(dir_we), .dir_wdata(dir_wdata), .dir_rdata(dir_rdata),
        .ind_req(ind_req), .ind_sel(ind_sel), .ind_we(ind_we), .ind_wdata(ind_wdata),
        .ind_busy(ind_busy), .ind_done(ind_done), .ind_invalid(ind_invalid),
        .ind_rdata(ind_rdata)
    );

    task automatic check_val(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_mem [128];
    int m_bank, m_rd, m_dr, m_ir, m_ph, m_pa, m_ptr, m_wd;
    bit m_we, m_done, m_inv;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            m_bank = 0; m_rd = 0; m_dr = 0; m_ir = 0; m_ph = 0;
            m_pa = 0; m_ptr = 0; m_wd = 0; m_we = 0; m_done = 0; m_inv = 0;
        end else begin
            int nrd, ndr;
            bit iw;
            nrd = m_mem[m_bank * 8 + rd_idx];
            ndr = m_mem[dir_addr];
            iw = 0;
            m_done = 0;
            m_inv = 0;
            if (m_ph == 0) begin
                if (ind_req) begin
                    m_we = ind_we; m_wd = ind_wdata;
                    m_pa = m_bank * 8 + ind_sel;
                    m_ph = 1;
                end
            end else if (m_ph == 1) begin
                m_ptr = m_mem[m_pa];
                m_ph = 2;
            end else begin
                m_done = 1;
                if (m_ptr >= 128) m_inv = 1;
                else if (m_we) iw = 1;
                else m_ir = m_mem[m_ptr];
                m_ph = 0;
            end
            if (wr_en)  m_mem[m_bank * 8 + wr_idx] = wr_data;
            if (dir_we) m_mem[dir_addr] = dir_wdata;
            if (iw)     m_mem[m_ptr] = m_wd;
            if (bank_wr_en) m_bank = bank_wr_val;
            m_rd = nrd;
            m_dr = ndr;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            check_val("R1 rd_data vs model", rd_data, m_rd);
            check_val("R4 dir_rdata vs model", dir_rdata, m_dr);
            check_val("R2 cur_bank vs model", cur_bank, m_bank);
            check_val("R5 ind_busy vs model", ind_busy, (m_ph != 0) ? 1 : 0);
            check_val("R5 ind_done vs model", ind_done, m_done);
            check_val("R7 ind_invalid vs model", ind_invalid, m_inv);
            check_val("R6 ind_rdata vs model", ind_rdata, m_ir);
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_bank(input int b);
        bank_wr_en = 1; bank_wr_val = 2'(b);
        tick();
        bank_wr_en = 0;
    endtask

    task automatic wreg(input int idx, input int d);
        wr_en = 1; wr_idx = 3'(idx); wr_data = 8'(d);
        tick();
        wr_en = 0;
    endtask

    task automatic wdir(input int a, input int d);
        dir_we = 1; dir_addr = 5'(a); dir_wdata = 8'(d);
        tick();
        dir_we = 0;
    endtask

    task automatic ind_op(input int sel, input int we, input int wd, input int exp_inv);
        ind_req = 1; ind_sel = sel[0]; ind_we = we[0]; ind_wdata = 8'(wd);
        tick();
        ind_req = 0; ind_we = 0;
        check_val("R5 busy after accept", ind_busy, 1);
        tick();
        check_val("R5 no done in fetch", ind_done, 0);
        tick();
        check_val("R5 done on third edge", ind_done, 1);
        check_val("R5 idle at done", ind_busy, 0);
        check_val(exp_inv ? "R7 invalid flagged" : "R11 invalid low on valid pointer",
                  ind_invalid, exp_inv);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; bank_wr_en = 0; bank_wr_val = 0; rd_idx = 0; wr_en = 0; wr_idx = 0;
        wr_data = 0; dir_addr = 0; dir_we = 0; dir_wdata = 0; ind_req = 0; ind_sel = 0;
        ind_we = 0; ind_wdata = 0;
        repeat (3) tick();
        // R3 reset state
        check_val("R3 cur_bank", cur_bank, 0);
        check_val("R3 rd_data", rd_data, 0);
        check_val("R3 dir_rdata", dir_rdata, 0);
        check_val("R3 ind_busy", ind_busy, 0);
        check_val("R3 ind_done", ind_done, 0);
        check_val("R3 ind_invalid", ind_invalid, 0);
        check_val("R3 ind_rdata", ind_rdata, 0);
        rst_n = 1;
        cmp_on = 1;

        // R8 read and write of the same byte in one cycle
        rd_idx = 3; wr_en = 1; wr_idx = 3; wr_data = 8'h55;
        tick();
        wr_en = 0;
        check_val("R8 old value on collision", rd_data, 0);
        tick();
        check_val("R8 new value next cycle", rd_data, 8'h55);

        // R1 R2 fill every bank through the register port
        for (int b = 0; b < 4; b++) begin
            set_bank(b);
            for (int r = 0; r < 8; r++) wreg(r, 8'h40 + 16 * b + r);
        end
        for (int a = 0; a < 32; a++) begin
            dir_addr = 5'(a);
            tick();
            check_val("R2 bank map seen on direct port", dir_rdata, 8'h40 + 16 * (a / 8) + a % 8);
        end

        // R4 direct write seen by register read in bank 1
        wdir(8'h0A, 8'hA5);
        set_bank(1);
        rd_idx = 2;
        tick();
        check_val("R4 direct to register alias", rd_data, 8'hA5);

        // R9 direct write beats register write on the same byte
        wr_en = 1; wr_idx = 5; wr_data = 8'h11;
        dir_we = 1; dir_addr = 5'h0D; dir_wdata = 8'h22;
        tick();
        wr_en = 0; dir_we = 0;
        tick();
        check_val("R9 direct over register", dir_rdata, 8'h22);

        // R5 R6 indirect write then read through bank 2 pointers
        set_bank(2);
        wreg(1, 8'h25);
        wreg(0, 8'h25);
        ind_op(1, 1, 8'h9C, 0);
        ind_op(0, 0, 0, 0);
        check_val("R6 indirect read data", ind_rdata, 8'h9C);

        // R10 request while busy is ignored
        ind_req = 1; ind_sel = 0; ind_we = 0;
        tick();
        ind_sel = 1; ind_we = 1; ind_wdata = 8'hEE;
        tick();
        ind_req = 0; ind_we = 0;
        tick();
        ind_op(0, 0, 0, 0);
        check_val("R10 busy request ignored", ind_rdata, 8'h9C);

        // R7 pointer of 80H or above
        wreg(1, 8'h90);
        ind_op(1, 1, 8'h77, 1);
        dir_addr = 5'h10;
        tick();
        check_val("R7 no write on invalid", dir_rdata, 8'h25);
        ind_op(1, 0, 0, 1);
        check_val("R7 rdata kept on invalid", ind_rdata, 8'h9C);

        // R5 pointer bank is the one active at acceptance
        wreg(0, 8'h00);
        wreg(0, 8'h25);
        bank_wr_en = 1; bank_wr_val = 3;
        ind_req = 1; ind_sel = 0; ind_we = 0;
        tick();
        bank_wr_en = 0; ind_req = 0;
        tick();
        tick();
        check_val("R5 pointer from old bank", ind_rdata, 8'h9C);

        // Mixed traffic against the reference model
        for (int n = 0; n < 3000; n++) begin
            bank_wr_en = ($urandom % 8) == 0;
            bank_wr_val = 2'($urandom);
            rd_idx = 3'($urandom);
            wr_en = $urandom % 2;
            wr_idx = 3'($urandom);
            wr_data = 8'($urandom);
            dir_addr = 5'($urandom);
            dir_we = ($urandom % 4) == 0;
            dir_wdata = 8'($urandom);
            ind_req = $urandom % 2;
            ind_sel = 1'($urandom);
            ind_we = 1'($urandom);
            ind_wdata = 8'($urandom);
            tick();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule